// File: doc/BRIEF.md
# I2C Configuration Register Port

This block is an I2C target that holds the frequency-select bytes of a six-channel clock generator. A bus controller writes one byte to one register per transaction, or reads one byte back. A read first writes the register pointer, then issues a repeated START and readdresses the target with the read bit set. The 7-bit bus address is not fixed. It is looked up from two strap inputs, and each strap can be low, high or left open, which gives nine possible addresses. Register 0x00 is a broadcast: a write to it loads the same byte into all six channel registers. Registers 0x01 to 0x06 each hold one channel. Any higher register number is reserved.

Both bus lines are synchronised to the system clock and cleaned by a filter that ignores pulses shorter than `FILT_CYC` cycles. The target drives SDA only low, through `sda_oe`. Every change of `sda_oe` is delayed by `HOLD_CYC` cycles after a falling SCL edge has been seen, so the data hold time on the bus is respected. A written byte reaches the channel registers only when the STOP that closes the transaction arrives. The six channel bytes appear in parallel on `chan_cfg` for the clock-generation logic.

The transfer state machine has ten states:
- `ST_IDLE`: bus free.
- `ST_DEV`, `ST_REG`, `ST_WDATA`: shifting in the address byte, the register byte and the data byte.
- `ST_DEV_ACK`, `ST_REG_ACK`, `ST_WDATA_ACK`: the acknowledge slot after each of those bytes.
- `ST_RDATA`, `ST_RDATA_ACK`: shifting a byte out, then the controller's acknowledge slot.
- `ST_SKIP`: ignore the bus until the next START or STOP.

The transitions, in the order the state machine checks them:
- A START from any state goes to `ST_DEV`.
- A STOP from any state goes to `ST_IDLE`.
- Otherwise each falling SCL edge moves the machine on:
  - After eight address bits, `ST_DEV` goes to `ST_DEV_ACK` when the address matches, and to `ST_SKIP` when it does not.
  - `ST_DEV_ACK` goes to `ST_RDATA` for a read, or to `ST_REG` for a write.
  - After eight register bits, `ST_REG` goes to `ST_REG_ACK`.
  - `ST_REG_ACK` goes to `ST_WDATA`.
  - After eight data bits, `ST_WDATA` goes to `ST_WDATA_ACK`.
  - `ST_WDATA_ACK` goes to `ST_SKIP`.
  - After eight bits, `ST_RDATA` goes to `ST_RDATA_ACK`.
  - `ST_RDATA_ACK` goes to `ST_SKIP`.

Top module: `i2cr_port`

## Requirements
- R1: Each strap is coded 2'b00 = low, 2'b01 = high, 2'b10 or 2'b11 = open. The address, as (strap0, strap1), is:
  - open/open 0x68, low/open 0x64, high/open 0x62
  - open/low 0x6C, low/low 0x69, high/low 0x70
  - open/high 0x71, low/high 0x72, high/high 0x74

  The target acknowledges its own address only.
- R2: A write is START, address with R/W=0, register byte, data byte. Each of the three bytes is acknowledged by pulling SDA low during the ninth clock. The data reaches the registers only when the closing STOP is detected, and not before it.
- R3: A write to register n (1 to 6) changes channel n, which is `chan_cfg[8n-1:8n-8]`, and no other channel.
- R4: A write to register 0x00 loads the data byte into all six channels.
- R5: A write to a register above 0x06 is acknowledged and changes nothing. A read of such a register returns 0x00.
- R6: A read is START, address with R/W=0, register byte, repeated START, address with R/W=1, then one byte driven MSB first. It returns the addressed register. Register 0x00 reads as channel 1.
- R7: Only one data byte is moved per transaction. Bytes after a write's data byte are not acknowledged and not stored. Bytes after a read's byte are not driven, so they read 0xFF.
- R8: A transaction with a non-matching address is never acknowledged and changes no register.
- R9: A START or STOP in the middle of a byte abandons the transfer. A write whose data byte is followed by a repeated START instead of a STOP is discarded.
- R10: A pulse on SCL or SDA shorter than `FILT_CYC` clock cycles has no effect.
- R11: `sda_oe` never changes within `HOLD_CYC` cycles after SCL falls. `HOLD_CYC` must be at least 2.
- R12: After reset, the channels hold channel 1 = 0x08, channels 2 to 4 = 0x07, and channels 5 and 6 = 0x00, and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| strap0 | input | 2 | First address strap code |
| strap1 | input | 2 | Second address strap code |
| sda_oe | output | 1 | When high, the data line is pulled low |
| chan_cfg | output | 8*NCH | Channel bytes; channel n in bits [8n-1:8n-8] |

## Verification
The in-line properties check the per-cycle behaviour:
- The register file's update rules: single-channel writes, broadcast writes, and reserved writes that leave every channel stable.
- A commit happens only in the cycle after a STOP.
- The SDA driver starts pulling low only in an acknowledge or read-data state.
- `sda_oe` holds across the cycles that follow a falling SCL.
- `sda_oe` is quiet in `ST_IDLE`.

Address decoding over all nine strap pairs, read data content, burst rejection, glitch immunity and aborted transfers are shown only by the bench's bus scenarios. In those scenarios a behavioural register model is compared against `chan_cfg` on every clock.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } phase_t;

    // Strap level: 0 = open, 1 = low, 2 = high.
    function automatic logic [1:0] strap_level(input logic [1:0] code);
        if (code[1])
            return 2'd0;
        else if (code[0])
            return 2'd2;
        else
            return 2'd1;
    endfunction

    function automatic logic [6:0] strap_addr(input logic [1:0] s0, input logic [1:0] s1);
        logic [3:0] idx;
        idx = {strap_level(s1), strap_level(s0)};
        case (idx)
            4'h0:    return 7'h68;
            4'h1:    return 7'h64;
            4'h2:    return 7'h62;
            4'h4:    return 7'h6C;
            4'h5:    return 7'h69;
            4'h6:    return 7'h70;
            4'h8:    return 7'h71;
            4'h9:    return 7'h72;
            4'hA:    return 7'h74;
            default: return 7'h68;
        endcase
    endfunction

endpackage

// File: rtl/i2cr_deglitch.sv
module i2cr_deglitch #(
    parameter int FILT_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    // A new level is accepted only after FILT_CYC cycles of disagreement.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clean <= 1'b1;
            cnt   <= '0;
        end else if (sync2 == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(FILT_CYC - 1)) begin
            clean <= sync2;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2cr_cfgregs.sv
module i2cr_cfgregs #(
    parameter int              NCH     = 6,
    parameter logic [NCH*8-1:0] RST_VAL = 48'h0000_0707_0708
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       waddr,
    input  logic [7:0]       wdata,
    input  logic [7:0]       raddr,
    output logic [7:0]       rdata,
    output logic [NCH*8-1:0] regs_flat
);
    logic [7:0] regs [NCH];

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= RST_VAL[i*8 +: 8];
            else if (we && (waddr == 8'd0 || waddr == 8'(i + 1)))
                regs[i] <= wdata;
        end

        assign regs_flat[i*8 +: 8] = regs[i];

        a_r3_chan_write: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr == 8'(i + 1)) |=> (regs[i] == $past(wdata)));
        a_r3_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr != 8'd0 && waddr != 8'(i + 1)) |=> $stable(regs[i]));
        a_r4_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr == 8'd0) |=> (regs[i] == $past(wdata)));
        a_r5_reserved_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (we && waddr > 8'(NCH)) |=> $stable(regs[i]));
    end

    // Register 0 reads back as channel 1; reserved numbers read as zero.
    always_comb begin
        rdata = '0;
        if (raddr == 8'd0)
            rdata = regs[0];
        else
            for (int i = 0; i < NCH; i++)
                if (raddr == 8'(i + 1))
                    rdata = regs[i];
    end

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
    import i2cr_pkg::*;
#(
    parameter int HOLD_CYC = 75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rdata,
    output logic       we,
    output logic [7:0] waddr,
    output logic [7:0] wdata,
    output logic [7:0] raddr,
    output logic       sda_oe
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    phase_t        state, nxt;
    logic          scl_q, sda_q;
    logic          rise, fall, start_ev, stop_ev;
    logic [7:0]    shreg, txreg, reg_ptr;
    logic [3:0]    bitcnt;
    logic          rw, pending, drv;
    logic [HW-1:0] hcnt;
    logic          byte_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign rise      = scl & ~scl_q;
    assign fall      = ~scl & scl_q;
    assign start_ev  = scl & scl_q & sda_q & ~sda;
    assign stop_ev   = scl & scl_q & ~sda_q & sda;
    assign byte_full = (bitcnt == 4'd8);

    always_comb begin
        nxt = state;
        if (start_ev)
            nxt = ST_DEV;
        else if (stop_ev)
            nxt = ST_IDLE;
        else if (fall) begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_full) nxt = (shreg[7:1] == dev_addr) ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:   nxt = rw ? ST_RDATA : ST_REG;
                ST_REG:       if (byte_full) nxt = ST_REG_ACK;
                ST_REG_ACK:   nxt = ST_WDATA;
                ST_WDATA:     if (byte_full) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: nxt = ST_SKIP;
                ST_RDATA:     if (byte_full) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: nxt = ST_SKIP;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Byte shifting, pointer, pending write and the next SDA drive value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            txreg   <= '0;
            reg_ptr <= '0;
            wdata   <= '0;
            bitcnt  <= '0;
            rw      <= 1'b0;
            pending <= 1'b0;
            drv     <= 1'b0;
            we      <= 1'b0;
        end else begin
            we <= 1'b0;
            if (start_ev || stop_ev) begin
                bitcnt  <= '0;
                pending <= 1'b0;
                drv     <= 1'b0;
                if (stop_ev && pending)
                    we <= 1'b1;
            end else if (rise) begin
                if (state inside {ST_DEV, ST_REG, ST_WDATA, ST_RDATA}) begin
                    shreg  <= {shreg[6:0], sda};
                    bitcnt <= bitcnt + 4'd1;
                end
            end else if (fall) begin
                unique case (state)
                    ST_DEV: if (byte_full) begin
                        rw     <= shreg[0];
                        bitcnt <= '0;
                        drv    <= (shreg[7:1] == dev_addr);
                    end
                    ST_DEV_ACK: begin
                        txreg <= rdata;
                        drv   <= rw & ~rdata[7];
                    end
                    ST_REG: if (byte_full) begin
                        reg_ptr <= shreg;
                        bitcnt  <= '0;
                        drv     <= 1'b1;
                    end
                    ST_WDATA: if (byte_full) begin
                        wdata   <= shreg;
                        pending <= 1'b1;
                        bitcnt  <= '0;
                        drv     <= 1'b1;
                    end
                    ST_RDATA: begin
                        if (byte_full) begin
                            bitcnt <= '0;
                            drv    <= 1'b0;
                        end else begin
                            txreg <= {txreg[6:0], 1'b0};
                            drv   <= ~txreg[6];
                        end
                    end
                    default: drv <= 1'b0;
                endcase
            end
        end
    end

    // Output stage: apply the drive value HOLD_CYC cycles after SCL falls.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe <= 1'b0;
            hcnt   <= '0;
        end else if (start_ev || stop_ev) begin
            sda_oe <= 1'b0;
            hcnt   <= '0;
        end else if (fall) begin
            hcnt <= HW'(HOLD_CYC);
        end else if (hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
            if (hcnt == HW'(1))
                sda_oe <= drv;
        end
    end

    assign waddr = reg_ptr;
    assign raddr = reg_ptr;

    a_r11_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> ##1 $stable(sda_oe));
    a_r2_drive_in_ack_or_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (state inside {ST_DEV_ACK, ST_REG_ACK, ST_WDATA_ACK, ST_RDATA}));
    a_r2_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $past(stop_ev));
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

endmodule

// File: rtl/i2cr_port.sv
module i2cr_port
    import i2cr_pkg::*;
#(
    parameter int               NCH      = 6,
    parameter int               FILT_CYC = 13,
    parameter int               HOLD_CYC = 75,
    parameter logic [NCH*8-1:0] RST_VAL  = 48'h0000_0707_0708
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [1:0]       strap0,
    input  logic [1:0]       strap1,
    output logic             sda_oe,
    output logic [NCH*8-1:0] chan_cfg
);
    logic [1:0] raw_lines, clean_lines;
    logic       we;
    logic [7:0] waddr, wdata, raddr, rdata;
    logic [6:0] dev_addr;

    assign raw_lines = {sda_in, scl_in};
    assign dev_addr  = strap_addr(strap0, strap1);

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2cr_deglitch #(.FILT_CYC(FILT_CYC)) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    i2cr_engine #(.HOLD_CYC(HOLD_CYC)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (clean_lines[0]),
        .sda      (clean_lines[1]),
        .dev_addr (dev_addr),
        .rdata    (rdata),
        .we       (we),
        .waddr    (waddr),
        .wdata    (wdata),
        .raddr    (raddr),
        .sda_oe   (sda_oe)
    );

    i2cr_cfgregs #(.NCH(NCH), .RST_VAL(RST_VAL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (raddr),
        .rdata     (rdata),
        .regs_flat (chan_cfg)
    );

endmodule

// File: tb/i2cr_port_test.sv
`timescale 1ns/1ps
module i2cr_port_test;
    localparam int NCH = 6;
    localparam int FILT = 4;
    localparam int HOLD = 8;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] strap0 = 2'b10, strap1 = 2'b10;
    logic sda_oe;
    logic [NCH*8-1:0] chan_cfg;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0, errs = 0;
    int settle = 0, mism = 0, hold_bad = 0, oe_changes = 0, since_fall = 100;
    logic [7:0] m [NCH];
    logic pend_v = 1'b0;
    logic [7:0] pend_r, pend_d;
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    i2cr_port #(.NCH(NCH), .FILT_CYC(FILT), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .strap0(strap0), .strap1(strap1), .sda_oe(sda_oe), .chan_cfg(chan_cfg));

    function automatic logic [6:0] bench_addr(input logic [1:0] s0, input logic [1:0] s1);
        int l0, l1;
        l0 = s0[1] ? 0 : (s0[0] ? 2 : 1);
        l1 = s1[1] ? 0 : (s1[0] ? 2 : 1);
        case (l1)
            0: return (l0 == 0) ? 7'h68 : (l0 == 1) ? 7'h64 : 7'h62;
            1: return (l0 == 0) ? 7'h6C : (l0 == 1) ? 7'h69 : 7'h70;
            default: return (l0 == 0) ? 7'h71 : (l0 == 1) ? 7'h72 : 7'h74;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] r);
        if (r == 8'd0) return m[0];
        if (r <= 8'(NCH)) return m[r - 1];
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the channel outputs against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            settle++;
            if (settle > 24)
                for (int k = 0; k < NCH; k++)
                    if (chan_cfg[k*8 +: 8] !== m[k]) mism++;
        end
    end

    // Hold monitor: sda_oe must not move soon after SCL falls.
    always @(posedge clk) begin
        if (prev_scl && !scl_m) since_fall = 0;
        else since_fall++;
        if (rst_n && sda_oe !== prev_oe) begin
            oe_changes++;
            if (!scl_m && since_fall < HOLD) hold_bad++;
        end
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0;
        pend_v = 1'b0;
    endtask

    task automatic do_stop();
        waitq(); sda_m = 1'b0;
        waitq(); scl_m = 1'b1;
        waitq(); sda_m = 1'b1;
        settle = 0;
        if (pend_v) begin
            if (pend_r == 8'd0) for (int k = 0; k < NCH; k++) m[k] = pend_d;
            else if (pend_r <= 8'(NCH)) m[pend_r - 1] = pend_d;
        end
        pend_v = 1'b0;
        waitq(); waitq();
    endtask

    task automatic xfer_bit(input logic b, input logic glitch, output logic s);
        waitq();
        sda_m = b;
        if (glitch) begin
            repeat (4) @(negedge clk);
            scl_m = 1'b1;
            repeat (FILT - 2) @(negedge clk);
            scl_m = 1'b0;
        end
        waitq(); scl_m = 1'b1;
        waitq(); s = sda_line;
        waitq(); scl_m = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] b, input logic glitch, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], glitch && i == 3, s);
        xfer_bit(1'b1, 1'b0, s);
        ack = (s == 1'b0);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            xfer_bit(1'b1, 1'b0, s);
            d[i] = s;
        end
        xfer_bit(~mack, 1'b0, s);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                             input logic glitch, output logic a0, output logic a1, output logic a2);
        do_start();
        put_byte({a, 1'b0}, 1'b0, a0);
        put_byte(r, 1'b0, a1);
        put_byte(d, glitch, a2);
        if (a == bench_addr(strap0, strap1)) begin
            pend_v = 1'b1; pend_r = r; pend_d = d;
        end
    endtask

    task automatic read_reg(input logic [6:0] a, input logic [7:0] r, output logic [7:0] d, output logic ok);
        logic x0, x1, x2;
        do_start();
        put_byte({a, 1'b0}, 1'b0, x0);
        put_byte(r, 1'b0, x1);
        do_start();
        put_byte({a, 1'b1}, 1'b0, x2);
        get_byte(1'b0, d);
        do_stop();
        ok = x0 & x1 & x2;
    endtask

    initial begin
        logic a0, a1, a2, ok, s;
        logic [7:0] d;
        logic [1:0] codes [3];
        codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b10;
        m[0] = 8'h08; m[1] = 8'h07; m[2] = 8'h07; m[3] = 8'h07; m[4] = 8'h00; m[5] = 8'h00;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R12: reset values
        chk("R12 reset channels", 32'(chan_cfg), 32'h0707_0708);
        chk("R12 reset upper channels", 32'(chan_cfg[47:32]), 32'h0000);
        chk("R12 reset sda_oe", 32'(sda_oe), 0);

        // R2: acks, no update before STOP, update after STOP; R3 single channel
        write_reg(7'h68, 8'h03, 8'h05, 1'b0, a0, a1, a2);
        chk("R2 address ack", 32'(a0), 1);
        chk("R2 register ack", 32'(a1), 1);
        chk("R2 data ack", 32'(a2), 1);
        repeat (30) @(negedge clk);
        chk("R2 no update before STOP", 32'(chan_cfg[23:16]), 32'h07);
        do_stop();
        chk("R3 channel 3 written", 32'(chan_cfg[23:16]), 32'h05);
        chk("R3 channel 2 untouched", 32'(chan_cfg[15:8]), 32'h07);

        // R6: read back through repeated START
        read_reg(7'h68, 8'h03, d, ok);
        chk("R6 read acks", 32'(ok), 1);
        chk("R6 read channel 3", 32'(d), 32'(model_read(8'h03)));

        // R4: broadcast
        write_reg(7'h68, 8'h00, 8'h02, 1'b0, a0, a1, a2);
        do_stop();
        chk("R4 broadcast all", 32'(chan_cfg[31:0]), 32'h0202_0202);
        chk("R4 broadcast upper", 32'(chan_cfg[47:32]), 32'h0202);

        // R3 + R6: register 0 reads channel 1
        write_reg(7'h68, 8'h01, 8'h0F, 1'b0, a0, a1, a2);
        do_stop();
        read_reg(7'h68, 8'h00, d, ok);
        chk("R6 register 0 reads channel 1", 32'(d), 32'h0F);
        chk("R3 channel 2 after ch1 write", 32'(chan_cfg[15:8]), 32'h02);

        // R5: reserved register
        write_reg(7'h68, 8'h07, 8'h55, 1'b0, a0, a1, a2);
        do_stop();
        chk("R5 reserved write acked", 32'(a2), 1);
        chk("R5 reserved write no change", 32'(chan_cfg[47:40]), 32'h02);
        read_reg(7'h68, 8'h09, d, ok);
        chk("R5 reserved read zero", 32'(d), 32'h00);

        // R9: repeated START after data discards the write
        write_reg(7'h68, 8'h02, 8'h0A, 1'b0, a0, a1, a2);
        do_start();
        do_stop();
        chk("R9 repeated START discards write", 32'(chan_cfg[15:8]), 32'h02);

        // R9: STOP mid-byte, then START mid-byte followed by a full write
        do_start();
        put_byte({7'h68, 1'b0}, 1'b0, a0);
        for (int i = 0; i < 4; i++) xfer_bit(1'b0, 1'b0, s);
        do_stop();
        do_start();
        put_byte({7'h68, 1'b0}, 1'b0, a0);
        for (int i = 0; i < 4; i++) xfer_bit(1'b1, 1'b0, s);
        write_reg(7'h68, 8'h03, 8'h06, 1'b0, a0, a1, a2);
        do_stop();
        chk("R9 write after mid-byte abort", 32'(chan_cfg[23:16]), 32'h06);
        chk("R9 address ack after abort", 32'(a0 & a1 & a2), 1);

        // R7: extra write byte rejected, extra read byte released
        write_reg(7'h68, 8'h04, 8'h11, 1'b0, a0, a1, a2);
        put_byte(8'h22, 1'b0, a1);
        do_stop();
        chk("R7 extra write byte not acked", 32'(a1), 0);
        chk("R7 first byte kept", 32'(chan_cfg[31:24]), 32'h11);
        chk("R7 next channel untouched", 32'(chan_cfg[39:32]), 32'h02);
        do_start();
        put_byte({7'h68, 1'b0}, 1'b0, a0);
        put_byte(8'h04, 1'b0, a0);
        do_start();
        put_byte({7'h68, 1'b1}, 1'b0, a0);
        get_byte(1'b1, d);
        chk("R7 first read byte", 32'(d), 32'h11);
        get_byte(1'b0, d);
        do_stop();
        chk("R7 second read byte released", 32'(d), 32'hFF);

        // R8: foreign address
        write_reg(7'h6A, 8'h05, 8'h09, 1'b0, a0, a1, a2);
        do_stop();
        chk("R8 foreign address no ack", 32'({a0, a1, a2}), 0);
        chk("R8 foreign address no change", 32'(chan_cfg[39:32]), 32'h02);

        // R10: short SCL pulse inside the data byte
        write_reg(7'h68, 8'h05, 8'h03, 1'b1, a0, a1, a2);
        do_stop();
        chk("R10 glitch ignored", 32'(chan_cfg[39:32]), 32'h03);

        // R1: all nine strap pairs, plus one neighbour that must be refused
        for (int j = 0; j < 3; j++) begin
            for (int i = 0; i < 3; i++) begin
                strap0 = codes[i];
                strap1 = codes[j];
                repeat (4) @(negedge clk);
                do_start();
                put_byte({bench_addr(codes[i], codes[j]), 1'b0}, 1'b0, a0);
                do_stop();
                chk("R1 strap address ack", 32'(a0), 1);
            end
        end
        strap0 = 2'b11; strap1 = 2'b00;
        repeat (4) @(negedge clk);
        do_start();
        put_byte({7'h68, 1'b0}, 1'b0, a0);
        do_stop();
        chk("R1 open code 11 gives 0x6C, not 0x68", 32'(a0), 0);

        repeat (40) @(negedge clk);
        chk("R3 R4 R5 per-clock model agreement", 32'(mism), 0);
        chk("R11 hold after SCL fall", 32'(hold_bad), 0);
        chk("R11 drive activity seen", 32'(oe_changes > 0), 1);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule